// File: doc/BRIEF.md
# Oscillator Race Response Core

This block turns a race between two free-running oscillator signals into a response word for a challenge. It takes two banks of oscillator lines, picks one line from each bank with the same challenge value, and counts rising edges on the two chosen lines in the system clock domain. When either count reaches full scale, the count of the other (slower) line is latched as the response. Because the oscillators' frequencies differ from die to die, the latched count is a device-dependent answer to the challenge.

The challenge comes either from an input port or from an internal maximal-length LFSR. In LFSR mode the LFSR advances after each completed race, so a new race starts on its own. A change of challenge, or a low enable, clears both counters and restarts the race. After a race ends, the counters hold and the response stays on the outputs until the next race ends. The oscillators themselves are outside this block. The oscillator inputs are treated as asynchronous and are synchronized inside.

Top module: `ro_race_puf`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), `resp_o`, `resp_lo_o`, `done_o` and `tie_o` become 0, and the LFSR is loaded with the seed value 1.
- R2: A challenge value c selects line c of bank A and line c of bank B. Pulses on any other line have no effect on the response.
- R3: Each rising edge on a selected line advances that line's counter by exactly one. A pulse must stay high for at least two clock cycles and low for at least two.
- R4: A race ends in the clock cycle in which either counter reaches 2^CNT_W-1. The response is then the other counter's value in that cycle, and `done_o` is high for exactly one cycle, in the cycle after.
- R5: If both counters reach full scale in the same cycle, the response is all ones and `tie_o` is 1. Otherwise `tie_o` is 0. `tie_o` changes only together with the response.
- R6: After a race ends, both counters hold, no further `done_o` pulse appears and the response stays stable until a new race is started.
- R7: While `en_i` is low, both counters are cleared and `done_o` stays low. A race starts when `en_i` is high.
- R8: A change of the active challenge clears both counters and starts a new race.
- R9: With `chal_src_i`=1 the LFSR supplies the challenge. Its next state is {q[3:0], q[4]^q[2]} (x^5+x^3+1). It advances once per race completed in that mode, visits all 31 nonzero states and never reaches zero. `chal_used_o` shows the challenge in effect, which is `chal_i` when `chal_src_i`=0.
- R10: `resp_lo_o` equals the low 8 bits of the response, with zeros added on the left when CNT_W is below 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable; low clears the counters |
| chal_src_i | input | 1 | 1: LFSR supplies the challenge, 0: `chal_i` supplies it |
| chal_i | input | SEL_W | External challenge |
| osc_a_i | input | N_OSC | Oscillator bank A (asynchronous) |
| osc_b_i | input | N_OSC | Oscillator bank B (asynchronous) |
| resp_o | output | CNT_W | Latched response |
| resp_lo_o | output | 8 | Low byte of the response |
| done_o | output | 1 | One-cycle pulse when a response is latched |
| tie_o | output | 1 | Both counters saturated in the same cycle |
| chal_used_o | output | SEL_W | Challenge currently in effect |

## Verification
Two functions can fall in the same clock cycle: both counters reaching full scale together, and one line's final edge arriving in the cycle in which the other line saturates. The bench provokes both by pulsing the two selected lines in the same clock cycles. When both pulse on every step, the race ends as a tie, which must give an all-ones response and a raised tie flag. When the slow line pulses on a step that is also the fast line's last step, that edge must be included in the latched count. A narrow counter lets every challenge in both banks be swept. Each expected count is worked out as floor((2^W-2)/k)+1 for a slow line that pulses every k-th step.

// File: rtl/puf_pkg.sv
// Package: shared helpers for the oscillator race core.
// Assumes LFSR widths from 2 to 8 bits.
package puf_pkg;

    localparam int LFSR_MAX_W = 8;

    // Returns the feedback tap mask of a maximal-length Fibonacci LFSR
    // that shifts toward the MSB. Bit i set means q[i] feeds the XOR.
    function automatic logic [LFSR_MAX_W-1:0] lfsr_taps(input int width);
        logic [LFSR_MAX_W-1:0] m;
        case (width)
            2:       m = 8'b0000_0011;
            3:       m = 8'b0000_0110;
            4:       m = 8'b0000_1100;
            5:       m = 8'b0001_0100;
            6:       m = 8'b0011_0000;
            7:       m = 8'b0110_0000;
            default: m = 8'b1011_1000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
// Module: osc_edge_sync
// Synchronizes a bank of asynchronous oscillator lines into the clock
// domain with two flops per line. A third flop holds the previous value,
// so a one-cycle pulse marks each rising edge.
// Assumes each line stays high and low for at least two clock cycles.
module osc_edge_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Purpose: the synchronizer chain and the delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: a rising edge is a new high after a low.
    assign rise_o = sync_q & ~prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R3

endmodule

// File: rtl/osc_sel_mux.sv
// Module: osc_sel_mux
// Picks one edge-pulse line out of a bank with a binary select.
// Indexes beyond the bank size select nothing (output low).
module osc_sel_mux #(
    parameter int N     = 32,
    parameter int SEL_W = 5
) (
    input  logic [N-1:0]     line_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             pick_o
);

    logic [N-1:0] hit;

    // One-hot decode of the select ANDed with each line.
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hit[i] = line_i[i] & (sel_i == SEL_W'(i));
    end

    // Purpose: OR the one possible hit together.
    assign pick_o = |hit;

endmodule

// File: rtl/race_counter.sv
// Module: race_counter
// Edge counter for one side of the race. It shows its next value
// combinationally so the controller can detect full scale in the same
// cycle as the last edge. Assumes the controller drops run_i after
// full scale, so the count never wraps.
module race_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             edge_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             full_nxt_o
);

    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] cnt_q;

    // Purpose: add one for a counted edge.
    assign nxt_o      = cnt_q + CNT_W'(run_i & edge_i);
    assign full_nxt_o = run_i & (nxt_o == FULL);
    assign cnt_o      = cnt_q;

    // Purpose: clear at start of a race, otherwise take the next value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt_o;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !clr_i) |=> (cnt_q == FULL)); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R3

endmodule

// File: rtl/chal_lfsr.sv
// Module: chal_lfsr
// Fibonacci LFSR that supplies pseudo-random challenges. The seed is
// 1 on reset, and the register advances only when step_i is high.
// Assumes a width that has a tap entry in puf_pkg.
module chal_lfsr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] q_o
);

    localparam logic [puf_pkg::LFSR_MAX_W-1:0] TAPS_FULL = puf_pkg::lfsr_taps(W);
    localparam logic [W-1:0] TAPS = TAPS_FULL[W-1:0];

    logic [W-1:0] q;
    logic         fb;

    // Purpose: XOR of the tapped bits.
    assign fb = ^(q & TAPS);

    // Purpose: seed on reset, shift on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= W'(1);
        end else if (step_i) begin
            q <= {q[W-2:0], fb};
        end
    end

    assign q_o = q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0); // R9
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(q)); // R9

endmodule

// File: rtl/ro_race_puf.sv
// Module: ro_race_puf (top)
// Races two oscillator lines, one chosen from each bank by a shared
// challenge. The count of the slower line is latched when the faster
// one reaches full scale. Restart happens when enable is low or the
// active challenge changes. Assumes a LFSR width (log2 of the bank size)
// of 2 to 8 bits.
module ro_race_puf #(
    parameter int N_OSC = 32,
    parameter int CNT_W = 32,
    parameter int LO_W  = 8,
    parameter int SEL_W = $clog2(N_OSC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             chal_src_i,
    input  logic [SEL_W-1:0] chal_i,
    input  logic [N_OSC-1:0] osc_a_i,
    input  logic [N_OSC-1:0] osc_b_i,
    output logic [CNT_W-1:0] resp_o,
    output logic [LO_W-1:0]  resp_lo_o,
    output logic             done_o,
    output logic             tie_o,
    output logic [SEL_W-1:0] chal_used_o
);

    logic [N_OSC-1:0] rise_a, rise_b;
    logic             pick_a, pick_b;
    logic [SEL_W-1:0] lfsr_q, sel, sel_q;
    logic             restart, run, running_q, end_hit;
    logic [CNT_W-1:0] cnt_a, cnt_b, nxt_a, nxt_b;
    logic             full_a, full_b;
    logic [CNT_W-1:0] resp_q;
    logic             done_q, tie_q;

    osc_edge_sync #(.WIDTH(N_OSC)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .async_i(osc_a_i), .rise_o(rise_a));
    osc_edge_sync #(.WIDTH(N_OSC)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .async_i(osc_b_i), .rise_o(rise_b));

    osc_sel_mux #(.N(N_OSC), .SEL_W(SEL_W)) u_mux_a (
        .line_i(rise_a), .sel_i(sel), .pick_o(pick_a));
    osc_sel_mux #(.N(N_OSC), .SEL_W(SEL_W)) u_mux_b (
        .line_i(rise_b), .sel_i(sel), .pick_o(pick_b));

    chal_lfsr #(.W(SEL_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step_i(end_hit & chal_src_i), .q_o(lfsr_q));

    // Purpose: choose the challenge source and find restart conditions.
    always_comb begin
        sel     = chal_src_i ? lfsr_q : chal_i;
        restart = !en_i || (sel != sel_q);
        run     = running_q && !restart;
    end

    race_counter #(.CNT_W(CNT_W)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .run_i(run),
        .edge_i(pick_a), .cnt_o(cnt_a), .nxt_o(nxt_a), .full_nxt_o(full_a));
    race_counter #(.CNT_W(CNT_W)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .run_i(run),
        .edge_i(pick_b), .cnt_o(cnt_b), .nxt_o(nxt_b), .full_nxt_o(full_b));

    // Purpose: the race ends when either side saturates this cycle.
    assign end_hit = full_a | full_b;

    // Purpose: race state, challenge history and response latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            running_q <= 1'b1;
            resp_q    <= '0;
            done_q    <= 1'b0;
            tie_q     <= 1'b0;
        end else begin
            sel_q  <= sel;
            done_q <= end_hit;
            if (restart) begin
                running_q <= 1'b1;
            end else if (end_hit) begin
                running_q <= 1'b0;
            end
            if (end_hit) begin
                tie_q <= full_a & full_b;
                if (full_a && full_b) begin
                    resp_q <= '1;
                end else if (full_a) begin
                    resp_q <= nxt_b;
                end else begin
                    resp_q <= nxt_a;
                end
            end
        end
    end

    // Low byte view, zero-extended when the counter is narrow.
    if (CNT_W >= LO_W) begin : g_lo_slice
        assign resp_lo_o = resp_q[LO_W-1:0];
    end else begin : g_lo_ext
        assign resp_lo_o = {{(LO_W-CNT_W){1'b0}}, resp_q};
    end

    assign resp_o      = resp_q;
    assign done_o      = done_q;
    assign tie_o       = tie_q;
    assign chal_used_o = sel;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R4
    AST_TIE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        tie_q |-> (resp_q == '1)); // R5
    AST_NO_DONE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_q); // R7
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(resp_q) && $stable(tie_q))); // R6
    AST_CLEAR_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_a == '0 && cnt_b == '0)); // R8

endmodule

// File: tb/tb_ro_race_puf.sv
// Bench: sweeps every challenge on a 6-bit counter configuration with
// expected counts computed arithmetically.
module tb_ro_race_puf;

    localparam int N     = 32;
    localparam int W     = 6;
    localparam int SW    = 5;
    localparam int FULL  = (1 << W) - 1;
    localparam int STEPS = FULL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          src = 1'b0;
    logic [SW-1:0] chal = '0;
    logic [N-1:0]  osc_a = '0;
    logic [N-1:0]  osc_b = '0;
    logic [W-1:0]  resp;
    logic [7:0]    resp_lo;
    logic          done, tie;
    logic [SW-1:0] chal_used;

    int n_chk = 0;
    int n_err = 0;
    int n_done = 0;
    logic [W-1:0] last_resp = '0;
    logic         last_tie = 1'b0;

    always #10 clk = ~clk;

    ro_race_puf #(.N_OSC(N), .CNT_W(W), .LO_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .chal_src_i(src), .chal_i(chal),
        .osc_a_i(osc_a), .osc_b_i(osc_b), .resp_o(resp), .resp_lo_o(resp_lo),
        .done_o(done), .tie_o(tie), .chal_used_o(chal_used));

    // Records each done pulse seen at the outputs.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            last_resp = resp;
            last_tie  = tie;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One pulse step: lines in the masks high for 3 cycles, then low 3.
    task automatic step(input logic [N-1:0] ma, input logic [N-1:0] mb);
        @(negedge clk);
        osc_a = ma;
        osc_b = mb;
        repeat (3) @(negedge clk);
        osc_a = '0;
        osc_b = '0;
        repeat (2) @(negedge clk);
    endtask

    // Selected lines pulse every ka / kb steps, all other lines every step.
    task automatic pulses(input int c, input int ka, input int kb, input int n);
        for (int s = 0; s < n; s++) begin
            logic [N-1:0] ma, mb;
            ma = '1;
            mb = '1;
            ma[c] = (s % ka) == 0;
            mb[c] = (s % kb) == 0;
            step(ma, mb);
        end
    endtask

    task automatic restart_en();
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // Full race with a check of the latched result.
    task automatic race(input int c, input int ka, input int kb, input string req);
        int d0, slow, exp;
        logic exp_tie;
        chal = SW'(c);
        restart_en();
        d0 = n_done;
        pulses(c, ka, kb, STEPS);
        repeat (4) @(negedge clk);
        slow = (ka > kb) ? ka : kb;
        exp_tie = (ka == 1) && (kb == 1);
        exp = exp_tie ? FULL : ((STEPS - 1) / slow + 1);
        chk({req, " done count"}, n_done - d0, 1);
        chk({req, " response"}, last_resp, exp);
        chk({req, " tie flag R5"}, last_tie, exp_tie);
        chk({req, " low byte R10"}, resp_lo, exp);
    endtask

    initial begin
        logic [SW-1:0] model;
        int d0;
        logic [W-1:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 resp", resp, 0);
        chk("R1 resp_lo", resp_lo, 0);
        chk("R1 done", done, 0);
        chk("R1 tie", tie, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 manual challenge shown", chal_used, 0);

        // R2, R3, R4: sweep every challenge, each bank as the slow side.
        for (int c = 0; c < N; c++) begin
            race(c, 1, (c % 5) + 2, "R2 R4 A fast");
            race(c, (c % 3) + 2, 1, "R2 R3 B fast");
        end

        // R5: both lines saturate in the same cycle.
        race(7, 1, 1, "R5 tie");
        race(20, 1, 1, "R5 tie");
        race(20, 1, 2, "R5 tie cleared");

        // R6: after done, extra pulses do not change anything.
        held = resp;
        d0 = n_done;
        pulses(20, 1, 1, 10);
        repeat (4) @(negedge clk);
        chk("R6 no second done", n_done - d0, 0);
        chk("R6 response held", resp, held);

        // R7: enable low mid-race clears, no done while low.
        chal = 5'd9;
        restart_en();
        d0 = n_done;
        pulses(9, 1, 1, 40);
        @(negedge clk);
        en = 1'b0;
        pulses(9, 1, 1, 30);
        chk("R7 no done while disabled", n_done - d0, 0);
        en = 1'b1;
        pulses(9, 1, 4, STEPS);
        repeat (4) @(negedge clk);
        chk("R7 one done after re-enable", n_done - d0, 1);
        chk("R7 counters restarted", last_resp, (STEPS - 1) / 4 + 1);

        // R8: challenge change mid-race restarts the race.
        chal = 5'd3;
        restart_en();
        d0 = n_done;
        pulses(3, 1, 1, 40);
        chal = 5'd4;
        pulses(4, 3, 1, STEPS);
        repeat (4) @(negedge clk);
        chk("R8 one done", n_done - d0, 1);
        chk("R8 fresh count", last_resp, (STEPS - 1) / 3 + 1);

        // R9: LFSR mode, full period of 31 states.
        @(negedge clk);
        en = 1'b0;
        src = 1'b1;
        repeat (2) @(negedge clk);
        model = 5'd1;
        chk("R9 seed", chal_used, model);
        en = 1'b1;
        for (int i = 0; i < 31; i++) begin
            d0 = n_done;
            for (int s = 0; s < STEPS; s++) begin
                step('1, (s % 2) == 0 ? '1 : '0);
            end
            repeat (4) @(negedge clk);
            model = {model[3:0], model[4] ^ model[2]};
            chk("R9 one done per race", n_done - d0, 1);
            chk("R9 race result", last_resp, (STEPS - 1) / 2 + 1);
            chk("R9 next challenge", chal_used, model);
            chk("R9 never zero", chal_used == 0, 0);
        end
        chk("R9 period 31 returns to seed", chal_used, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule